// File: doc/BRIEF.md
# Terminal-Side Call Answer Controller

This block is the control logic on the terminal side of a serial modem link. It answers an incoming call and then manages the request-to-send exchange that allows a local serial transmitter to run. It watches four modem status lines (data set ready, ring, carrier present and clear to send), all already synchronised to the block clock. It drives terminal-ready and request-to-send back to the modem, and a transmit-enable to the local transmitter. The signal voltage levels, the modem itself and the serial data path lie outside the block.

With the data set ready, the controller counts rising edges of the ring line. It raises terminal-ready on the first edge and answers on the second. If the second edge does not arrive within a programmable number of clock edges, it returns to idle. Once the modem reports a carrier, the controller raises request-to-send whenever the transmitter has a request pending. It enables transmission only while the modem answers with clear-to-send. If carrier or data-set-ready is lost, the link drops at once. A bypass input serves a three-wire hookup: in that mode the status lines are ignored and the far end is taken as always ready.

The block moves no data, so every pin is a plain level with no valid/ready handshake. A 3-bit status output reports the current phase of the call.

Top module: `dte_call_ctrl`

## Requirements
- R1: Reset puts the controller in idle: status_o = 0 (idle), and dtr_o, rts_o and tx_enable are all low.
- R2: In idle with dsr_i high, a rising edge on ri_i moves the controller to status 1 (ringing) and raises dtr_o. With dsr_i low, ring edges leave the controller idle.
- R3: In ringing, a second rising edge on ri_i moves the controller to status 2 (answered). A ring line held high counts as one edge only.
- R4: If no new ring edge is sampled within ring_timeout clock edges after the last counted ring edge, the ring count clears and the controller returns to idle with dtr_o low. With ring_timeout = T and the counted edge at clock edge E, the return happens at edge E+T. ring_timeout must be at least 1.
- R5: In answered, the controller moves to status 3 (carrier) when cd_i is high. Until then it stays answered.
- R6: In carrier, tx_request high moves the controller to status 4 (requesting), which raises rts_o and keeps tx_enable low. While tx_request is low, rts_o stays low.
- R7: In requesting, cts_i high moves the controller to status 5 (sending), which raises tx_enable. In sending, cts_i low returns it to requesting with tx_enable low and rts_o high.
- R8: In requesting or sending, tx_request low together with tx_idle high returns the controller to carrier and lowers rts_o. While tx_idle is low, the controller stays where it is.
- R9: dsr_i low in any non-idle state, or cd_i low in carrier, requesting or sending, returns the controller to idle. dtr_o, rts_o and tx_enable then fall on the same clock edge.
- R10: With bypass_mode high, dsr_i, cd_i and cts_i are treated as high and ring counting is skipped. From idle the controller enters carrier on the next edge, and requesting moves on to sending without waiting for cts_i.
- R11: The outputs follow the status: dtr_o is high in every state except idle, rts_o is high in states 4 and 5, and tx_enable is high in state 5 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_mode | input | 1 | Three-wire mode: status lines ignored, far end assumed ready |
| ring_timeout | input | TMR_W | Clock edges allowed between counted ring edges (at least 1) |
| dsr_i | input | 1 | Data set ready from the modem |
| ri_i | input | 1 | Ring line from the modem |
| cd_i | input | 1 | Carrier present from the modem |
| cts_i | input | 1 | Clear to send from the modem |
| tx_request | input | 1 | Local transmitter has data pending |
| tx_idle | input | 1 | Local transmitter has finished its current character |
| dtr_o | output | 1 | Terminal ready to the modem |
| rts_o | output | 1 | Request to send to the modem |
| tx_enable | output | 1 | Permission for the local transmitter to send |
| status_o | output | 3 | Call phase: 0 idle, 1 ringing, 2 answered, 3 carrier, 4 requesting, 5 sending |

## Verification
Every result is due exactly one clock edge after the input that causes it is sampled. The state register is the only stage between inputs and outputs, and the outputs are decoded from it without further delay. The bench drives inputs just after the falling edge and reads outputs at the falling edge that follows the next rising edge. A behavioural model, built on a ring counter and an edge-count since the last ring, is compared with all four outputs on every cycle. Directed checks fix the ring window boundary: status is still ringing after edge E+T-1 and idle after edge E+T.

// File: rtl/call_ctrl_pkg.sv
package call_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RINGING  = 3'd1,
    ST_ANSWERED = 3'd2,
    ST_CARRIER  = 3'd3,
    ST_REQUEST  = 3'd4,
    ST_SENDING  = 3'd5
  } call_state_e;

endpackage

// File: rtl/call_line_cond.sv
// Folds the three-wire bypass into the modem status lines.
module call_line_cond (
  input  logic bypass_i,
  input  logic dsr_i,
  input  logic cd_i,
  input  logic cts_i,
  output logic dsr_ok_o,
  output logic cd_ok_o,
  output logic cts_ok_o
);

  assign dsr_ok_o = bypass_i | dsr_i;
  assign cd_ok_o  = bypass_i | cd_i;
  assign cts_ok_o = bypass_i | cts_i;

endmodule

// File: rtl/call_ring_counter.sv
// Counts rising ring edges and ends the count when the gap grows too long.
module call_ring_counter #(
  parameter int RINGS = 2,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ri_i,
  input  logic             arm_i,
  input  logic [TMR_W-1:0] timeout_i,
  output logic             rise_o,
  output logic             answer_o,
  output logic             expired_o
);

  localparam int CNT_W = $clog2(RINGS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RINGS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RINGS);

  logic             ri_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] gap_q;
  logic             window_end;

  assign rise_o     = ri_i & ~ri_q;
  assign answer_o   = rise_o & (cnt_q == CNT_LAST);
  assign window_end = (gap_q == (timeout_i - TMR_W'(1)));
  assign expired_o  = arm_i & ~rise_o & (cnt_q != '0) & window_end;

  always_ff @(posedge clk) begin
    if (!rst_n) ri_q <= 1'b0;
    else        ri_q <= ri_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !arm_i) begin
      cnt_q <= '0;
      gap_q <= '0;
    end else if (rise_o) begin
      cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
      gap_q <= '0;
    end else if (expired_o) begin
      cnt_q <= '0;
      gap_q <= '0;
    end else if (cnt_q != '0) begin
      gap_q <= gap_q + TMR_W'(1);
    end
  end

endmodule

// File: rtl/call_fsm.sv
// Call sequencing: ring, answer, carrier, request, send.
module call_fsm
  import call_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bypass_i,
  input  logic        dsr_ok_i,
  input  logic        cd_ok_i,
  input  logic        cts_ok_i,
  input  logic        ring_rise_i,
  input  logic        ring_answer_i,
  input  logic        ring_expired_i,
  input  logic        tx_request_i,
  input  logic        tx_idle_i,
  output call_state_e state_o,
  output logic        ring_arm_o
);

  call_state_e state_q, state_d;
  logic        link_lost;
  logic        tx_done;

  assign link_lost  = ~dsr_ok_i | ~cd_ok_i;
  assign tx_done    = ~tx_request_i & tx_idle_i;
  assign ring_arm_o = dsr_ok_i & ((state_q == ST_IDLE) | (state_q == ST_RINGING));
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (bypass_i)                     state_d = ST_CARRIER;
        else if (dsr_ok_i && ring_rise_i) state_d = ring_answer_i ? ST_ANSWERED : ST_RINGING;
      end
      ST_RINGING: begin
        if (!dsr_ok_i)           state_d = ST_IDLE;
        else if (ring_answer_i)  state_d = ST_ANSWERED;
        else if (ring_expired_i) state_d = ST_IDLE;
      end
      ST_ANSWERED: begin
        if (!dsr_ok_i)    state_d = ST_IDLE;
        else if (cd_ok_i) state_d = ST_CARRIER;
      end
      ST_CARRIER: begin
        if (link_lost)         state_d = ST_IDLE;
        else if (tx_request_i) state_d = ST_REQUEST;
      end
      ST_REQUEST: begin
        if (link_lost)     state_d = ST_IDLE;
        else if (tx_done)  state_d = ST_CARRIER;
        else if (cts_ok_i) state_d = ST_SENDING;
      end
      ST_SENDING: begin
        if (link_lost)      state_d = ST_IDLE;
        else if (tx_done)   state_d = ST_CARRIER;
        else if (!cts_ok_i) state_d = ST_REQUEST;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/call_out_decode.sv
// Modem control levels and status code from the call state.
module call_out_decode
  import call_ctrl_pkg::*;
(
  input  call_state_e state_i,
  output logic        dtr_o,
  output logic        rts_o,
  output logic        tx_enable_o,
  output logic [2:0]  status_o
);

  assign dtr_o       = (state_i != ST_IDLE);
  assign rts_o       = (state_i == ST_REQUEST) | (state_i == ST_SENDING);
  assign tx_enable_o = (state_i == ST_SENDING);
  assign status_o    = state_i;

endmodule

// File: rtl/dte_call_ctrl.sv
module dte_call_ctrl
  import call_ctrl_pkg::*;
#(
  parameter int RINGS = 2,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass_mode,
  input  logic [TMR_W-1:0] ring_timeout,
  input  logic             dsr_i,
  input  logic             ri_i,
  input  logic             cd_i,
  input  logic             cts_i,
  input  logic             tx_request,
  input  logic             tx_idle,
  output logic             dtr_o,
  output logic             rts_o,
  output logic             tx_enable,
  output logic [2:0]       status_o
);

  logic        dsr_ok, cd_ok, cts_ok;
  logic        ring_rise, ring_answer, ring_expired, ring_arm;
  call_state_e state;

  call_line_cond i_cond (
    .bypass_i (bypass_mode),
    .dsr_i    (dsr_i),
    .cd_i     (cd_i),
    .cts_i    (cts_i),
    .dsr_ok_o (dsr_ok),
    .cd_ok_o  (cd_ok),
    .cts_ok_o (cts_ok)
  );

  call_ring_counter #(.RINGS(RINGS), .TMR_W(TMR_W)) i_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .ri_i      (ri_i),
    .arm_i     (ring_arm),
    .timeout_i (ring_timeout),
    .rise_o    (ring_rise),
    .answer_o  (ring_answer),
    .expired_o (ring_expired)
  );

  call_fsm i_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .bypass_i       (bypass_mode),
    .dsr_ok_i       (dsr_ok),
    .cd_ok_i        (cd_ok),
    .cts_ok_i       (cts_ok),
    .ring_rise_i    (ring_rise),
    .ring_answer_i  (ring_answer),
    .ring_expired_i (ring_expired),
    .tx_request_i   (tx_request),
    .tx_idle_i      (tx_idle),
    .state_o        (state),
    .ring_arm_o     (ring_arm)
  );

  call_out_decode i_dec (
    .state_i     (state),
    .dtr_o       (dtr_o),
    .rts_o       (rts_o),
    .tx_enable_o (tx_enable),
    .status_o    (status_o)
  );

endmodule

// File: rtl/dte_call_ctrl_chk.sv
module dte_call_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bypass_mode,
  input logic       dsr_i,
  input logic       ri_i,
  input logic       cd_i,
  input logic       cts_i,
  input logic       tx_request,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       tx_enable,
  input logic [2:0] status_o
);

  AST_TXEN_NEEDS_RTS: assert property (@(posedge clk) disable iff (!rst_n) tx_enable |-> rts_o); // R11
  AST_RTS_NEEDS_DTR: assert property (@(posedge clk) disable iff (!rst_n) rts_o |-> dtr_o); // R11
  AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) status_o <= 3'd5); // R11
  AST_RING_EDGE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n) (status_o == 3'd1 && !ri_i) |=> status_o != 3'd2); // R3
  AST_NO_RTS_UNREQUESTED: assert property (@(posedge clk) disable iff (!rst_n) (status_o == 3'd3 && !tx_request) |=> !rts_o); // R6
  AST_SEND_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n) (!bypass_mode && !cts_i) |=> !tx_enable); // R7
  AST_DSR_LOSS: assert property (@(posedge clk) disable iff (!rst_n) (!bypass_mode && !dsr_i) |=> !dtr_o); // R9
  AST_CD_LOSS: assert property (@(posedge clk) disable iff (!rst_n) (!bypass_mode && !cd_i && rts_o) |=> !rts_o); // R9
  AST_BYPASS_LINK_UP: assert property (@(posedge clk) disable iff (!rst_n) (bypass_mode && status_o == 3'd0) |=> status_o == 3'd3); // R10

endmodule

bind dte_call_ctrl dte_call_ctrl_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bypass_mode (bypass_mode),
  .dsr_i       (dsr_i),
  .ri_i        (ri_i),
  .cd_i        (cd_i),
  .cts_i       (cts_i),
  .tx_request  (tx_request),
  .dtr_o       (dtr_o),
  .rts_o       (rts_o),
  .tx_enable   (tx_enable),
  .status_o    (status_o)
);

// File: tb/test_dte_call_ctrl.sv
`timescale 1ns/1ps
module test_dte_call_ctrl;

  localparam int TMR_W   = 16;
  localparam int RING_TO = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bypass_mode = 1'b0;
  logic [TMR_W-1:0] ring_timeout = TMR_W'(RING_TO);
  logic             dsr_i = 1'b0, ri_i = 1'b0, cd_i = 1'b0, cts_i = 1'b0;
  logic             tx_request = 1'b0, tx_idle = 1'b1;
  logic             dtr_o, rts_o, tx_enable;
  logic [2:0]       status_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dte_call_ctrl #(.TMR_W(TMR_W)) i_dte_call_ctrl (
    .clk(clk), .rst_n(rst_n), .bypass_mode(bypass_mode), .ring_timeout(ring_timeout),
    .dsr_i(dsr_i), .ri_i(ri_i), .cd_i(cd_i), .cts_i(cts_i),
    .tx_request(tx_request), .tx_idle(tx_idle),
    .dtr_o(dtr_o), .rts_o(rts_o), .tx_enable(tx_enable), .status_o(status_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ring(int hi);
    ri_i = 1'b1; cyc(hi);
    ri_i = 1'b0; cyc(1);
  endtask

  // Behavioural reference: call phase, rings counted, edges since last ring
  int m_state = 0, m_rings = 0, m_since = 0;
  bit m_ri_last = 1'b0;
  bit m_rise, m_d, m_c, m_t, m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_rings = 0; m_since = 0; m_ri_last = 1'b0;
    end else begin
      m_rise = ri_i && !m_ri_last;
      m_ri_last = ri_i;
      m_d = bypass_mode || dsr_i;
      m_c = bypass_mode || cd_i;
      m_t = bypass_mode || cts_i;
      m_done = !tx_request && tx_idle;
      case (m_state)
        0: if (bypass_mode) m_state = 3;
           else if (m_d && m_rise) begin m_rings = 1; m_since = 0; m_state = 1; end
        1: if (!m_d) begin m_rings = 0; m_state = 0; end
           else if (m_rise) begin
             m_rings++; m_since = 0;
             if (m_rings >= 2) begin m_rings = 0; m_state = 2; end
           end else begin
             m_since++;
             if (m_since >= RING_TO) begin m_rings = 0; m_state = 0; end
           end
        2: if (!m_d) m_state = 0; else if (m_c) m_state = 3;
        3: if (!m_d || !m_c) m_state = 0; else if (tx_request) m_state = 4;
        4: if (!m_d || !m_c) m_state = 0; else if (m_done) m_state = 3; else if (m_t) m_state = 5;
        5: if (!m_d || !m_c) m_state = 0; else if (m_done) m_state = 3; else if (!m_t) m_state = 4;
        default: m_state = 0;
      endcase
    end
  end

  // R11: every cycle, outputs against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 model status", int'(status_o), m_state);
      chk("R11 model dtr", int'(dtr_o), int'(m_state != 0));
      chk("R11 model rts", int'(rts_o), int'(m_state >= 4));
      chk("R11 model tx_enable", int'(tx_enable), int'(m_state == 5));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 status", int'(status_o), 0);
    chk("R1 dtr", int'(dtr_o), 0);
    chk("R1 rts", int'(rts_o), 0);
    chk("R1 tx_enable", int'(tx_enable), 0);

    // ring without data set ready is ignored
    ring(2); cyc(1);
    chk("R2 ring ignored without dsr", int'(status_o), 0);
    chk("R2 dtr low without dsr", int'(dtr_o), 0);

    // first ring, held level, then timeout at E+T
    dsr_i = 1'b1; cyc(2);
    ri_i = 1'b1; cyc(1);
    chk("R2 ringing", int'(status_o), 1);
    chk("R2 dtr raised", int'(dtr_o), 1);
    cyc(4);
    chk("R3 held ring counts once", int'(status_o), 1);
    ri_i = 1'b0; cyc(10);
    cyc(5);
    chk("R4 still ringing at E+T-1", int'(status_o), 1);
    cyc(1);
    chk("R4 idle at E+T", int'(status_o), 0);
    chk("R4 dtr low after timeout", int'(dtr_o), 0);

    // two rings answer
    ring(2);
    chk("R3 first ring", int'(status_o), 1);
    ri_i = 1'b1; cyc(1);
    chk("R3 answered", int'(status_o), 2);
    ri_i = 1'b0; cyc(2);
    chk("R5 waits for carrier", int'(status_o), 2);
    cd_i = 1'b1; cyc(1);
    chk("R5 carrier", int'(status_o), 3);
    cyc(3);
    chk("R6 no rts without request", int'(rts_o), 0);

    tx_request = 1'b1; cyc(1);
    chk("R6 requesting", int'(status_o), 4);
    chk("R6 rts high", int'(rts_o), 1);
    chk("R6 tx_enable low", int'(tx_enable), 0);
    cyc(3);
    chk("R7 waits for cts", int'(status_o), 4);
    cts_i = 1'b1; cyc(1);
    chk("R7 sending", int'(status_o), 5);
    chk("R7 tx_enable high", int'(tx_enable), 1);
    cts_i = 1'b0; cyc(1);
    chk("R7 cts drop back to request", int'(status_o), 4);
    chk("R7 tx_enable low on cts drop", int'(tx_enable), 0);
    cts_i = 1'b1; cyc(1);
    chk("R7 sending again", int'(status_o), 5);

    tx_idle = 1'b0; tx_request = 1'b0; cyc(3);
    chk("R8 holds while busy", int'(status_o), 5);
    chk("R8 rts held while busy", int'(rts_o), 1);
    tx_idle = 1'b1; cyc(1);
    chk("R8 back to carrier", int'(status_o), 3);
    chk("R8 rts low", int'(rts_o), 0);

    tx_request = 1'b1; cyc(2);
    chk("R7 request then send", int'(status_o), 5);
    cd_i = 1'b0; cyc(1);
    chk("R9 carrier loss idle", int'(status_o), 0);
    chk("R9 dtr low", int'(dtr_o), 0);
    chk("R9 rts low", int'(rts_o), 0);
    chk("R9 tx_enable low", int'(tx_enable), 0);

    ring(1); ring(1);
    chk("R3 answered again", int'(status_o), 2);
    dsr_i = 1'b0; cyc(1);
    chk("R9 dsr loss idle", int'(status_o), 0);
    chk("R9 dtr low on dsr loss", int'(dtr_o), 0);

    tx_request = 1'b0; cts_i = 1'b0;
    bypass_mode = 1'b1; cyc(1);
    chk("R10 bypass carrier", int'(status_o), 3);
    chk("R10 bypass dtr", int'(dtr_o), 1);
    tx_request = 1'b1; cyc(1);
    chk("R10 bypass request", int'(status_o), 4);
    cyc(1);
    chk("R10 bypass sends without cts", int'(status_o), 5);
    chk("R10 bypass tx_enable", int'(tx_enable), 1);
    cyc(5);
    chk("R10 line loss ignored", int'(status_o), 5);
    bypass_mode = 1'b0; cyc(1);
    chk("R9 loss seen after bypass off", int'(status_o), 0);

    cyc(3);
    report();
  end

endmodule